// File: doc/BRIEF.md
# Bus-Inactivity Automatic Power-Down Controller

This controller sits between a host microcontroller bus and the internal memories, logic arrays and I/O ports of a programmable peripheral. It watches the host's address strobe. When the strobe has not moved for a programmed number of system-clock cycles and the feature is enabled, the block enters power-down.

In power-down the address and data paths toward the internal arrays are clamped to zero, so bus noise or traffic meant for other devices cannot toggle anything inside. Every internal memory select is forced inactive. Each I/O port gets an output policy from its own 2-bit function field: its levels are held, it is released to high impedance, or it is left running because its level does not matter.

Any strobe transition wakes the block. Clearing the enable also wakes it. On wake-up the memory selects come back one cycle before the input clamp is released.

Top module: `apd_ctrl`

## Requirements
- R1: Each transition of `strobe` (rising or falling) clears the idle count. With `apd_en` high and no further transition, `asleep_o` rises at the (timeout+4)-th rising clock edge after the transition and is still low at the (timeout+3)-th. The +3 covers the three synchronizer and edge-detect flops.
- R2: While `apd_en` is low the block never enters power-down, and the idle count is held at zero.
- R3: During power-down, and for one further cycle after it ends, `addr_o` and `data_o` are zero whatever `bus_addr_i` and `bus_data_i` carry.
- R4: While `asleep_o` is high, `sel_o` is all zeros whatever `sel_raw_i` carries.
- R5: A port whose function field (bits 2k+1:2k of `port_func_i` for port k) is 2'b00 drives the `port_out_i` and `port_oe_i` values sampled at the entry clock edge for as long as power-down lasts.
- R6: A port with function 2'b01 or 2'b11 has all bits of its `port_oe_i` slice forced to zero on `port_oe_o` during power-down.
- R7: A port with function 2'b10 passes its live `port_out_i` and `port_oe_i` through in every mode.
- R8: A `strobe` transition while asleep drops `asleep_o` at the third rising edge after the transition, and `sel_o` follows `sel_raw_i` from then on. The address and data clamp is released one cycle later.
- R9: Clearing `apd_en` while asleep drops `asleep_o` at the next rising edge. The clamp is released one cycle later.
- R10: Outside power-down and its one-cycle release tail, `addr_o`, `data_o`, `sel_o`, `port_out_o` and `port_oe_o` equal their inputs.
- R11: Asynchronous active-low reset leaves the block awake with the clamp released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Host address strobe, asynchronous to clk |
| apd_en | input | 1 | Enables automatic power-down |
| timeout | input | TMO_W | Idle cycles required before entry |
| bus_addr_i | input | ADDR_W | Host address |
| bus_data_i | input | DATA_W | Host data |
| sel_raw_i | input | NUM_SEL | Decoded memory selects |
| port_func_i | input | 2*NUM_PORTS | Per-port function fields |
| port_out_i | input | NUM_PORTS*PORT_W | Port output levels from the core |
| port_oe_i | input | NUM_PORTS*PORT_W | Port output enables from the core |
| addr_o | output | ADDR_W | Address toward the internal arrays |
| data_o | output | DATA_W | Data toward the internal arrays |
| sel_o | output | NUM_SEL | Memory selects after the override |
| port_out_o | output | NUM_PORTS*PORT_W | Port output levels to the pads |
| port_oe_o | output | NUM_PORTS*PORT_W | Port output enables to the pads |
| asleep_o | output | 1 | High while in power-down |

## Verification
A second strobe transition is sent partway through the idle count. A design that failed to clear the count would enter power-down early. Wake-up is sampled cycle by cycle: releasing the clamp together with the selects, or waking one edge late, shows up as a mismatch at the third or fourth edge. The held ports get new core values after entry, so a design that tracks the inputs instead of freezing them, or that also tristates the don't-care port, is caught. Dropping the enable mid-sleep checks that exit is immediate and that no re-entry follows while the enable stays low.

// File: rtl/apd_ctrl.sv
module apd_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_SEL   = 4,
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int TMO_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strobe,
  input  logic                        apd_en,
  input  logic [TMO_W-1:0]            timeout,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [DATA_W-1:0]           bus_data_i,
  input  logic [NUM_SEL-1:0]          sel_raw_i,
  input  logic [2*NUM_PORTS-1:0]      port_func_i,
  input  logic [NUM_PORTS*PORT_W-1:0] port_out_i,
  input  logic [NUM_PORTS*PORT_W-1:0] port_oe_i,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [DATA_W-1:0]           data_o,
  output logic [NUM_SEL-1:0]          sel_o,
  output logic [NUM_PORTS*PORT_W-1:0] port_out_o,
  output logic [NUM_PORTS*PORT_W-1:0] port_oe_o,
  output logic                        asleep_o
);
  localparam int PV_W = NUM_PORTS * PORT_W;

  logic [2:0]       sync_q;
  logic             stb_edge;
  logic [TMO_W-1:0] idle_q;
  logic             sleep_q, sleep_d1_q, clamp;
  logic [PV_W-1:0]  hold_out_q, hold_oe_q;

  assign stb_edge = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], strobe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_q <= '0;
    else if (!apd_en || stb_edge) idle_q <= '0;
    else if (idle_q < timeout) idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q    <= 1'b0;
      sleep_d1_q <= 1'b0;
    end else begin
      sleep_d1_q <= sleep_q;
      if (!apd_en)
        sleep_q <= 1'b0;
      else if (sleep_q && stb_edge)
        sleep_q <= 1'b0;
      else if (!sleep_q && !stb_edge && idle_q >= timeout)
        sleep_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_out_q <= '0;
      hold_oe_q  <= '0;
    end else if (!sleep_q) begin
      hold_out_q <= port_out_i;
      hold_oe_q  <= port_oe_i;
    end
  end

  assign clamp    = sleep_q | sleep_d1_q;
  assign asleep_o = sleep_q;
  assign addr_o   = clamp   ? '0 : bus_addr_i;
  assign data_o   = clamp   ? '0 : bus_data_i;
  assign sel_o    = sleep_q ? '0 : sel_raw_i;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    logic [1:0] fn;
    assign fn = port_func_i[2*k +: 2];
    always_comb begin
      port_out_o[k*PORT_W +: PORT_W] = port_out_i[k*PORT_W +: PORT_W];
      port_oe_o[k*PORT_W +: PORT_W]  = port_oe_i[k*PORT_W +: PORT_W];
      if (sleep_q) begin
        case (fn)
          2'b00: begin
            port_out_o[k*PORT_W +: PORT_W] = hold_out_q[k*PORT_W +: PORT_W];
            port_oe_o[k*PORT_W +: PORT_W]  = hold_oe_q[k*PORT_W +: PORT_W];
          end
          2'b10:   ;
          default: port_oe_o[k*PORT_W +: PORT_W] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_SEL   = 4,
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int TMO_W     = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        apd_en,
  input logic [ADDR_W-1:0]           bus_addr_i,
  input logic [NUM_SEL-1:0]          sel_raw_i,
  input logic [2*NUM_PORTS-1:0]      port_func_i,
  input logic [NUM_PORTS*PORT_W-1:0] port_out_o,
  input logic [NUM_PORTS*PORT_W-1:0] port_oe_o,
  input logic [ADDR_W-1:0]           addr_o,
  input logic [DATA_W-1:0]           data_o,
  input logic [NUM_SEL-1:0]          sel_o,
  input logic                        asleep_o
);
  p_enter_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(apd_en));

  p_disable_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !apd_en |=> !asleep_o);

  p_sel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o |-> (sel_o == '0));

  p_clamp_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_o) |-> (addr_o == '0 && data_o == '0 && sel_o == sel_raw_i));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_o && !$past(asleep_o)) |-> (addr_o == bus_addr_i));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_chk
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_o && $past(asleep_o) && port_func_i[2*k +: 2] == 2'b00
       && $past(port_func_i[2*k +: 2]) == 2'b00)
      |-> (port_out_o[k*PORT_W +: PORT_W] == $past(port_out_o[k*PORT_W +: PORT_W])
           && port_oe_o[k*PORT_W +: PORT_W] == $past(port_oe_o[k*PORT_W +: PORT_W])));

    p_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_o && port_func_i[2*k] == 1'b1) |-> (port_oe_o[k*PORT_W +: PORT_W] == '0));
  end
endmodule

bind apd_ctrl apd_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEL(NUM_SEL),
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .TMO_W(TMO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .apd_en(apd_en), .bus_addr_i(bus_addr_i),
  .sel_raw_i(sel_raw_i), .port_func_i(port_func_i), .port_out_o(port_out_o),
  .port_oe_o(port_oe_o), .addr_o(addr_o), .data_o(data_o), .sel_o(sel_o),
  .asleep_o(asleep_o)
);

// File: tb/tb_apd_ctrl.sv
module tb_apd_ctrl;
  localparam int CLK_P = 10;
  localparam int T     = 10;
  localparam int NV    = 6;
  localparam logic [27:0] VEC [NV] = '{
    {16'h0000, 8'h00, 4'b0000},
    {16'hFFFF, 8'hFF, 4'b1111},
    {16'hA5A5, 8'h5A, 4'b0101},
    {16'h1234, 8'h80, 4'b1000},
    {16'h8001, 8'h01, 4'b0011},
    {16'h7FFE, 8'hC3, 4'b0110}
  };

  logic clk = 0, rst_n = 0, strobe = 0, apd_en = 0;
  logic [15:0] timeout = T;
  logic [15:0] bus_addr_i = '0;
  logic [7:0]  bus_data_i = '0;
  logic [3:0]  sel_raw_i = '0;
  logic [7:0]  port_func_i = 8'b11_10_01_00;
  logic [31:0] port_out_i = 32'h44332211, port_oe_i = 32'hFFFFFFFF;
  logic [15:0] addr_o;
  logic [7:0]  data_o;
  logic [3:0]  sel_o;
  logic [31:0] port_out_o, port_oe_o;
  logic        asleep_o;
  int checks = 0, fails = 0;

  apd_ctrl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sleep();
    for (int i = 0; i < 40 && !asleep_o; i++) tick(1);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(2);
    bus_addr_i = 16'hBEEF;
    #1;
    chk("R11 asleep", asleep_o, 0);
    chk("R11 addr", addr_o, 16'hBEEF);
    rst_n = 1;
    tick(1);

    for (int i = 0; i < NV; i++) begin
      {bus_addr_i, bus_data_i, sel_raw_i} = VEC[i];
      tick(1);
      chk("R10 addr", addr_o, VEC[i][27:12]);
      chk("R10 data", data_o, VEC[i][11:4]);
      chk("R10 sel", sel_o, VEC[i][3:0]);
    end
    tick(3 * T);
    chk("R2 no entry while disabled", asleep_o, 0);

    apd_en = 1; strobe = ~strobe;
    tick(8);
    strobe = ~strobe;
    tick(T + 3);
    chk("R1 not yet asleep", asleep_o, 0);
    tick(1);
    chk("R1 asleep", asleep_o, 1);

    port_out_i = 32'h88776655; port_oe_i = 32'h0F0F0F0F;
    tick(1);
    chk("R5 hold out", port_out_o[7:0], 8'h11);
    chk("R5 hold oe", port_oe_o[7:0], 8'hFF);
    chk("R6 port1 oe", port_oe_o[15:8], 8'h00);
    chk("R6 port3 oe", port_oe_o[31:24], 8'h00);
    chk("R7 port2 out", port_out_o[23:16], 8'h77);
    chk("R7 port2 oe", port_oe_o[23:16], 8'h0F);

    for (int i = 0; i < NV; i++) begin
      {bus_addr_i, bus_data_i, sel_raw_i} = VEC[i];
      tick(1);
      chk("R3 addr", addr_o, 0);
      chk("R3 data", data_o, 0);
      chk("R4 sel", sel_o, 0);
    end

    strobe = ~strobe;
    tick(2);
    chk("R8 still asleep", asleep_o, 1);
    tick(1);
    chk("R8 awake", asleep_o, 0);
    chk("R8 sel back", sel_o, VEC[NV-1][3:0]);
    chk("R8 clamp tail", addr_o, 0);
    tick(1);
    chk("R8 released", addr_o, VEC[NV-1][27:12]);
    chk("R10 port0 live", port_out_o[7:0], 8'h55);

    wait_sleep();
    chk("R1 re-entry", asleep_o, 1);
    apd_en = 0;
    tick(1);
    chk("R9 awake", asleep_o, 0);
    chk("R9 clamp tail", data_o, 0);
    tick(1);
    chk("R9 released", data_o, VEC[NV-1][11:4]);
    tick(3 * T);
    chk("R2 stays awake", asleep_o, 0);

    apd_en = 1;
    wait_sleep();
    chk("R1 sleep before reset", asleep_o, 1);
    rst_n = 0;
    #1;
    chk("R11 reset wakes", asleep_o, 0);
    chk("R11 reset releases", addr_o, VEC[NV-1][27:12]);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule